// File: doc/BRIEF.md
# AC-link Status Readback Responder

This block builds the incoming serial frame that a minimal audio DAC returns to its AC-link controller. Each frame starts with a 16-bit tag slot. The first bit of that slot tells the controller whether the device is operational. The next two bits mark whether the status address slot and the status data slot carry a valid answer. Every other position of the frame is zero-filled.

The block answers register read requests that the command decoder captured from the previous outgoing frame. The requested index is echoed in the status address slot. Only two vendor identification registers hold nonzero contents, and every other index reads back as zero. Write requests get no answer.

The frame is shifted out MSB first, one bit per rising bit-clock edge. A frame starts when SYNC is seen rising. The outgoing frame position is tracked by a saturating counter that SYNC resets.

Top module: `acl_status_resp`

## Requirements
- R1: Frame position 0, the first bit driven after the rising edge that first sees `sync_i` high following a low, carries the value of `ready_i`. A 1 means operational and a 0 means not ready.
- R2: While `ready_i` is low, every bit driven, tags and slot contents alike, is 0.
- R3: A read request is a `cmd_valid_i` strobe with `cmd_read_i`=1. A read request accepted before a frame starts is answered in that frame by setting tag positions 1 and 2, which are the slot 1 and slot 2 tags. Tag positions 3 to 15 are always 0. When several reads arrive before one frame start, the last one is answered.
- R4: In an answered frame, slot 1 is positions 16 to 35, MSB first. Its bit 19 is 0, bits 18:12 hold the requested 7-bit index, and bits 11:0 are 0. In a frame with no answer, the whole slot is 0.
- R5: Slot 2 is positions 36 to 55. Its bits 19:4 carry the register value and bits 3:0 are 0. Index 7Ch reads 574Dh, index 7Eh reads 4C09h, and every other index reads 0000h. In a frame with no answer, the whole slot is 0.
- R6: Positions 56 to 255, which are slots 3 to 12, are always 0.
- R7: A strobe with `cmd_read_i`=0 produces no answer and leaves any pending read intact. A read is answered in exactly one frame, and the frame that follows carries no tags unless a new read arrived.
- R8: Position p of the frame is driven on the p-th rising edge after the start edge. A request that arrives during a frame is answered in the next frame. After position 255, the output stays 0 until the next frame start.
- R9: While `rst_ni` is low, and after it rises until the first frame starts, `sdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock; data changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller; a rise starts a frame |
| ready_i | input | 1 | Device operational indication |
| cmd_valid_i | input | 1 | One-cycle strobe for a captured command |
| cmd_read_i | input | 1 | Captured command is a read (1) or a write (0) |
| cmd_index_i | input | IDX_W | Captured register index |
| sdata_o | output | 1 | Serial incoming-frame data, MSB first |

## Verification
The bench builds the block with its default widths: 20-bit slots, twelve data slots, a 16-bit tag slot and a 7-bit index. With only 128 indices, every index can be read back in its own frame. Each frame's tag, address, data and tail fields are compared against values the bench derives from the index arithmetic. On top of that sweep, directed frames cover write strobes, back-to-back reads, requests arriving mid-frame, frames that follow an answered one, and frames sent while not ready.

// File: rtl/acl_rb_pkg.sv
package acl_rb_pkg;
  localparam int unsigned NUM_VID = 2;
  // vendor identification table: index, contents
  localparam int unsigned VID_INDEX [NUM_VID] = '{32'h7C, 32'h7E};
  localparam int unsigned VID_VALUE [NUM_VID] = '{32'h574D, 32'h4C09};
endpackage

// File: rtl/acl_rb_frame_ctr.sv
module acl_rb_frame_ctr #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  output logic             start_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_BITS);

  logic             sync_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_o = sync_i & ~sync_q;

  always_comb begin
    if (start_o)            pos_o = '0;
    else if (cnt_q == IDLE) pos_o = IDLE;
    else                    pos_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cnt_q  <= IDLE;
    end else begin
      sync_q <= sync_i;
      cnt_q  <= pos_o;
    end
  end

  assign cnt_o = cnt_q;

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && cnt_q != IDLE) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && cnt_q == IDLE) |=> cnt_q == IDLE);
  a_r8_start_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> cnt_q == '0);
endmodule

// File: rtl/acl_rb_req_track.sv
module acl_rb_req_track #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_read_i,
  input  logic [IDX_W-1:0] cmd_index_i,
  output logic             resp_valid_o,
  output logic [IDX_W-1:0] resp_index_o
);
  logic             pend_q, resp_q;
  logic [IDX_W-1:0] pend_idx_q, resp_idx_q;
  logic             take_rd;

  assign take_rd = cmd_valid_i & cmd_read_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      resp_q     <= 1'b0;
      resp_idx_q <= '0;
    end else begin
      if (start_i) begin
        // answer what was pending before this frame began
        resp_q     <= pend_q;
        resp_idx_q <= pend_idx_q;
        pend_q     <= take_rd;
      end else if (take_rd) begin
        pend_q <= 1'b1;
      end
      if (take_rd) pend_idx_q <= cmd_index_i;
    end
  end

  assign resp_valid_o = resp_q;
  assign resp_index_o = resp_idx_q;

  a_r3_resp_from_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> resp_q == $past(pend_q));
  a_r7_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_read_i && !start_i) |=> pend_q == $past(pend_q));
  a_r7_resp_only_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(resp_q));
endmodule

// File: rtl/acl_rb_vid_rom.sv
module acl_rb_vid_rom
  import acl_rb_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic [IDX_W-1:0]  index_i,
  output logic [DATA_W-1:0] value_o
);
  logic [DATA_W-1:0] part [NUM_VID];

  for (genvar g = 0; g < NUM_VID; g++) begin : g_ent
    assign part[g] = (index_i == IDX_W'(VID_INDEX[g])) ? DATA_W'(VID_VALUE[g]) : '0;
  end

  always_comb begin
    value_o = '0;
    for (int i = 0; i < NUM_VID; i++) value_o |= part[i];
  end
endmodule

// File: rtl/acl_rb_slot_mux.sv
module acl_rb_slot_mux #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned SLOT_W = 20,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 9
) (
  input  logic [CNT_W-1:0]  pos_i,
  input  logic              resp_valid_i,
  input  logic [IDX_W-1:0]  resp_index_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              bit_o
);
  localparam int unsigned HEAD_W  = TAG_W + 2 * SLOT_W;
  localparam int unsigned HEAD_AW = $clog2(HEAD_W);
  localparam int unsigned ADR_PAD = SLOT_W - IDX_W - 1;
  localparam int unsigned DAT_PAD = SLOT_W - DATA_W;

  logic [TAG_W-1:0]   tag;
  logic [SLOT_W-1:0]  slot_adr, slot_dat;
  logic [HEAD_W-1:0]  head;
  logic [HEAD_AW-1:0] rel;
  logic               in_head;

  always_comb begin
    tag            = '0;
    tag[TAG_W-1]   = 1'b1;          // ready position, gated at the top
    tag[TAG_W-2]   = resp_valid_i;  // status address slot
    tag[TAG_W-3]   = resp_valid_i;  // status data slot
  end

  assign slot_adr = resp_valid_i ? {1'b0, resp_index_i, {ADR_PAD{1'b0}}} : '0;
  assign slot_dat = resp_valid_i ? {value_i, {DAT_PAD{1'b0}}} : '0;
  assign head     = {tag, slot_adr, slot_dat};

  assign in_head = pos_i < CNT_W'(HEAD_W);
  assign rel     = HEAD_AW'(HEAD_W - 1) - pos_i[HEAD_AW-1:0];
  assign bit_o   = in_head ? head[rel] : 1'b0;
endmodule

// File: rtl/acl_status_resp.sv
module acl_status_resp #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned DATA_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             ready_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_read_i,
  input  logic [IDX_W-1:0] cmd_index_i,
  output logic             sdata_o
);
  localparam int unsigned FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned TAIL_START = TAG_W + 2 * SLOT_W;

  logic              start;
  logic [CNT_W-1:0]  pos, cnt;
  logic              resp_valid;
  logic [IDX_W-1:0]  resp_index;
  logic [DATA_W-1:0] reg_value;
  logic              frame_bit;
  logic              sdata_q;

  acl_rb_frame_ctr #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .sync_i,
    .start_o(start), .pos_o(pos), .cnt_o(cnt)
  );

  acl_rb_req_track #(.IDX_W(IDX_W)) u_req (
    .clk_i, .rst_ni,
    .start_i(start),
    .cmd_valid_i, .cmd_read_i, .cmd_index_i,
    .resp_valid_o(resp_valid), .resp_index_o(resp_index)
  );

  acl_rb_vid_rom #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rom (
    .index_i(resp_index), .value_o(reg_value)
  );

  acl_rb_slot_mux #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_mux (
    .pos_i(pos), .resp_valid_i(resp_valid), .resp_index_i(resp_index),
    .value_i(reg_value), .bit_o(frame_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdata_q <= 1'b0;
    else         sdata_q <= ready_i & frame_bit;
  end

  assign sdata_o = sdata_q;

  a_r1_ready_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> sdata_o == $past(ready_i));
  a_r2_quiet_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !sdata_o);
  a_r6_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt >= CNT_W'(TAIL_START)) |-> !sdata_o);
  a_r3_no_tag_without_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(1) && !resp_valid) |-> !sdata_o);
endmodule

// File: tb/acl_status_resp_bench.sv
module acl_status_resp_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, sync, ready, cmd_valid, cmd_read;
  logic [6:0] cmd_index;
  logic       sdata_o;

  acl_status_resp u_acl_status_resp (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .ready_i(ready),
    .cmd_valid_i(cmd_valid), .cmd_read_i(cmd_read), .cmd_index_i(cmd_index),
    .sdata_o(sdata_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic exp_pend = 1'b0;
  logic [6:0] exp_idx = '0;
  logic [255:0] got;

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vid(input logic [6:0] i);
    if (i == 7'h7C) return 16'h574D;
    if (i == 7'h7E) return 16'h4C09;
    return 16'h0000;
  endfunction

  task automatic send_cmd(input logic rd, input logic [6:0] idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_index = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rd) begin exp_pend = 1'b1; exp_idx = idx; end
  endtask

  // spos: frame position after which a strobe is issued, -1 for none
  task automatic run_frame(input logic rdy, input int spos,
                           input logic srd, input logic [6:0] sidx);
    logic        hv;
    logic [6:0]  idx;
    logic [15:0] e_tag;
    logic [19:0] e_s1, e_s2;
    hv = exp_pend; idx = exp_idx; exp_pend = 1'b0;
    @(negedge clk);
    sync = 1'b1; ready = rdy;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      got[255-p] = sdata_o;
      cmd_valid = 1'b0;
      if (p == 15) sync = 1'b0;
      if (p == spos) begin
        cmd_valid = 1'b1; cmd_read = srd; cmd_index = sidx;
        if (srd) begin exp_pend = 1'b1; exp_idx = sidx; end
      end
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R8", "idle after frame", 256'(sdata_o), 256'(0));
    end
    if (!rdy) begin
      chk("R2", "frame while not ready", got, 256'(0));
    end else begin
      e_tag = {1'b1, hv, hv, 13'b0};
      e_s1  = hv ? {1'b0, idx, 12'b0} : 20'b0;
      e_s2  = hv ? {vid(idx), 4'b0} : 20'b0;
      chk("R1", "ready flag", 256'(got[255]), 256'(e_tag[15]));
      chk("R3", "tag bits", 256'(got[254:240]), 256'(e_tag[14:0]));
      chk("R4", "status address slot", 256'(got[239:220]), 256'(e_s1));
      chk("R5", "status data slot", 256'(got[219:200]), 256'(e_s2));
      chk("R6", "slots 3 to 12", 256'(got[199:0]), 256'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync = 1'b0; ready = 1'b0;
    cmd_valid = 1'b0; cmd_read = 1'b0; cmd_index = '0;
    repeat (3) @(negedge clk);
    chk("R9", "output in reset", 256'(sdata_o), 256'(0));
    rst_n = 1'b1; ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "output before first frame", 256'(sdata_o), 256'(0));

    // R1 R3: frame with no request
    run_frame(1'b1, -1, 1'b0, 7'h0);

    // R4 R5: every index read in its own frame
    for (int i = 0; i < 128; i++) begin
      send_cmd(1'b1, 7'(i));
      run_frame(1'b1, -1, 1'b0, 7'h0);
    end

    // R7: write only, no answer
    send_cmd(1'b0, 7'h7C);
    run_frame(1'b1, -1, 1'b0, 7'h0);

    // R7: write after read leaves read pending
    send_cmd(1'b1, 7'h7E);
    send_cmd(1'b0, 7'h7C);
    run_frame(1'b1, -1, 1'b0, 7'h0);

    // R3: last of two reads wins
    send_cmd(1'b1, 7'h7E);
    send_cmd(1'b1, 7'h7C);
    run_frame(1'b1, -1, 1'b0, 7'h0);

    // R8: mid-frame read answered next frame, then R7 answered once
    run_frame(1'b1, 100, 1'b1, 7'h7E);
    run_frame(1'b1, -1, 1'b0, 7'h0);
    run_frame(1'b1, -1, 1'b0, 7'h0);

    // R7: mid-frame write produces nothing
    run_frame(1'b1, 30, 1'b0, 7'h7C);
    run_frame(1'b1, -1, 1'b0, 7'h0);

    // R2: not ready frame consumes the request, all zero
    send_cmd(1'b1, 7'h7C);
    run_frame(1'b0, -1, 1'b0, 7'h0);
    run_frame(1'b1, -1, 1'b0, 7'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule